// File: doc/BRIEF.md
# Multi-Bit Error Flag Qualifier

This block sits beside the bus controller of a four-die non-volatile memory stack. The stack has one shared, active-low, open-drain flag that reports a double-bit error on the current read. That flag means nothing after power-up or after the stack leaves sleep until each of the four die has been enabled at least once. It can also pulse low at the start of any read. The qualifier watches the same enable and upper-address lines that the controller drives. From them it works out which die each access reaches. It records which die have been reached since reset or since sleep, and it samples the flag only at the controller's read-data strobe, once the record is full.

Two addressing modes exist. In combined mode, the shared enable is low and all per-die enables are high. The two upper address bits then pick the die, with a non-monotonic order. In individual mode, the shared enable is high and exactly one per-die enable is low. Any other enable pattern is a protocol error. Such a pattern is flagged and is neither recorded as an access nor sampled. Each qualified error is reported with the index of the die that was read. A saturating counter keeps the number of errors until the host clears it.

Top module: `mbe_qualifier`

## Requirements
- R1: While rst_n is low at a clock edge, the block clears flag_valid, err_valid, err_flag, err_die, proto_err and err_count after that edge.
- R2: In combined mode (all_en_n=0, die_en_n=4'b1111), the value of addr_hi selects the die as follows: 2'b00 gives die 0, 2'b01 gives die 1, 2'b10 gives die 3 and 2'b11 gives die 2.
- R3: In individual mode (all_en_n=1 with exactly one die_en_n bit k low), the access goes to die k whatever addr_hi holds. The pattern all_en_n=1, die_en_n=4'b1111 is idle and is not an access.
- R4: flag_valid goes high on the clock edge that registers the access which completes the set of all four die. It then stays high until reset or sleep.
- R5: A read strobe seen while flag_valid is low gives no err_valid and leaves err_count unchanged.
- R6: A cycle with rd_strobe=1, flag_valid=1 and a legal access makes err_valid high for one cycle after the edge, with err_flag = ~mbe_n and err_die = the decoded die. err_flag and err_die keep their values until the next such sample, and mbe_n has no effect in other cycles.
- R7: An illegal enable pattern raises proto_err for the cycle after the edge. This covers all_en_n=0 with any die_en_n bit low, and all_en_n=1 with two or more die_en_n bits low. The pattern does not mark any die as accessed and is not sampled.
- R8: While sleep is high, flag_valid is low after each edge, every enable, address and strobe input is ignored, and no die is recorded.
- R9: Each sample with err_flag=1 adds one to err_count. The count saturates at 2^CNT_W-1.
- R10: err_clr=1 at an edge sets err_count to 0 after that edge, even when an error is sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep | input | 1 | Stack in sleep; clears the access record |
| all_en_n | input | 1 | Combined-mode enable, active low |
| die_en_n | input | 4 | Per-die enables, active low |
| addr_hi | input | 2 | Upper two address bits |
| rd_strobe | input | 1 | Read-data valid point from the bus controller |
| mbe_n | input | 1 | Shared multi-bit error flag, active low |
| err_clr | input | 1 | Host clear of the error counter |
| flag_valid | output | 1 | All four die accessed since reset or sleep |
| err_valid | output | 1 | A qualified sample was taken on the previous edge |
| err_flag | output | 1 | Last sampled error state (1 = double-bit error) |
| err_die | output | 2 | Die index of the last sampled read |
| proto_err | output | 1 | Illegal enable pattern seen on the previous edge |
| err_count | output | CNT_W | Saturating count of sampled errors |

## Verification
The checker assumes that the flag input is valid at the strobe cycle. It also assumes that the controller raises rd_strobe only when it has finished a real read, and that sleep, reset and err_clr are synchronous levels. The bench changes inputs only on the falling edge and holds each pattern for one whole cycle, so every strobe meets a settled enable pattern. It uses only illegal patterns that R7 defines, so the error and no-record checks apply to inputs the decoder classifies without ambiguity.

// File: rtl/mbe_qual_pkg.sv
// Shared constants, types and the combined-mode die map for the error
// flag qualifier. Assumes a stack of exactly four die.
package mbe_qual_pkg;
    localparam int NUM_DIE = 4;
    localparam int DIE_W   = $clog2(NUM_DIE);

    typedef logic [DIE_W-1:0] die_idx_t;

    typedef enum logic [1:0] {
        SEL_IDLE = 2'd0,
        SEL_ONE  = 2'd1,
        SEL_BAD  = 2'd2
    } sel_kind_t;

    // Upper address bits to die index in combined mode (order is not binary).
    function automatic die_idx_t map_upper_addr(input logic [1:0] a);
        case (a)
            2'b00:   return die_idx_t'(0);
            2'b01:   return die_idx_t'(1);
            2'b10:   return die_idx_t'(3);
            default: return die_idx_t'(2);
        endcase
    endfunction
endpackage

// File: rtl/mbe_die_decode.sv
// Classifies the enable pattern of the current cycle as idle, a legal
// single-die access, or illegal. It also gives the target die.
// Assumes the inputs are synchronous to clk. Sleep forces idle.
module mbe_die_decode
    import mbe_qual_pkg::*;
(
    input  logic               sleep,
    input  logic               all_en_n,
    input  logic [NUM_DIE-1:0] die_en_n,
    input  logic [1:0]         addr_hi,
    output logic               acc_ok,
    output logic               acc_bad,
    output die_idx_t           acc_die,
    output logic [NUM_DIE-1:0] acc_onehot
);
    localparam int CW = DIE_W + 1;

    logic [CW-1:0] n_low;
    die_idx_t      ind_idx;
    sel_kind_t     kind;

    // Count active per-die enables and find the lowest active one.
    always_comb begin
        n_low   = '0;
        ind_idx = '0;
        for (int i = NUM_DIE - 1; i >= 0; i--) begin
            n_low = n_low + CW'(~die_en_n[i]);
            if (!die_en_n[i]) ind_idx = die_idx_t'(i);
        end
    end

    // Classify the pattern and choose the target die.
    always_comb begin
        kind    = SEL_IDLE;
        acc_die = '0;
        if (!sleep) begin
            if (!all_en_n) begin
                kind    = (n_low == '0) ? SEL_ONE : SEL_BAD;
                acc_die = map_upper_addr(addr_hi);
            end else if (n_low == CW'(1)) begin
                kind    = SEL_ONE;
                acc_die = ind_idx;
            end else if (n_low != '0) begin
                kind    = SEL_BAD;
            end
        end
    end

    assign acc_ok  = (kind == SEL_ONE);
    assign acc_bad = (kind == SEL_BAD);

    // One select line per die.
    for (genvar g = 0; g < NUM_DIE; g++) begin : g_sel
        assign acc_onehot[g] = acc_ok && (acc_die == die_idx_t'(g));
    end
endmodule

// File: rtl/mbe_touch_tracker.sv
// Keeps one bit per die that is set once the die has been accessed. Reset
// and sleep clear all bits. Assumes acc_onehot has at most one bit set.
module mbe_touch_tracker
    import mbe_qual_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep,
    input  logic [NUM_DIE-1:0] acc_onehot,
    output logic [NUM_DIE-1:0] touched,
    output logic               all_touched
);
    for (genvar g = 0; g < NUM_DIE; g++) begin : g_bit
        // Set this die's bit on an access; clear it on reset or sleep.
        always_ff @(posedge clk) begin
            if (!rst_n || sleep) touched[g] <= 1'b0;
            else if (acc_onehot[g]) touched[g] <= 1'b1;
        end
    end

    assign all_touched = &touched;
endmodule

// File: rtl/mbe_err_sampler.sv
// Captures the flag at a qualified read strobe together with the die
// index. Assumes mbe_n is settled whenever sample_en is high.
module mbe_err_sampler
    import mbe_qual_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sample_en,
    input  logic     mbe_n,
    input  die_idx_t acc_die,
    output logic     err_valid,
    output logic     err_flag,
    output die_idx_t err_die,
    output logic     err_hit
);
    // Comb pulse for the counter: a qualified sample that shows an error.
    assign err_hit = sample_en && !mbe_n;

    // Pulse err_valid for one cycle per sample.
    always_ff @(posedge clk) begin
        if (!rst_n) err_valid <= 1'b0;
        else        err_valid <= sample_en;
    end

    // Hold the last sampled flag and die index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
            err_die  <= '0;
        end else if (sample_en) begin
            err_flag <= !mbe_n;
            err_die  <= acc_die;
        end
    end
endmodule

// File: rtl/mbe_sat_counter.sv
// Saturating event counter with a synchronous clear that wins over a
// same-cycle increment.
module mbe_sat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count events and stop at CNT_MAX; clear takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)                 count <= '0;
        else if (inc && count != CNT_MAX)  count <= count + 1'b1;
    end
endmodule

// File: rtl/mbe_qualifier.sv
// Top of the error flag qualifier. It decodes the enables, records which
// die were accessed, samples the flag at the read strobe once all four are
// recorded, flags illegal enable patterns and counts sampled errors.
// Assumes all inputs are synchronous to clk.
module mbe_qualifier
    import mbe_qual_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             all_en_n,
    input  logic [3:0]       die_en_n,
    input  logic [1:0]       addr_hi,
    input  logic             rd_strobe,
    input  logic             mbe_n,
    input  logic             err_clr,
    output logic             flag_valid,
    output logic             err_valid,
    output logic             err_flag,
    output logic [1:0]       err_die,
    output logic             proto_err,
    output logic [CNT_W-1:0] err_count
);
    logic               acc_ok;
    logic               acc_bad;
    die_idx_t           acc_die;
    logic [NUM_DIE-1:0] acc_onehot;
    logic [NUM_DIE-1:0] touched;
    logic               sample_en;
    logic               err_hit;

    mbe_die_decode u_dec (
        .sleep(sleep), .all_en_n(all_en_n), .die_en_n(die_en_n),
        .addr_hi(addr_hi), .acc_ok(acc_ok), .acc_bad(acc_bad),
        .acc_die(acc_die), .acc_onehot(acc_onehot)
    );

    mbe_touch_tracker u_trk (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .acc_onehot(acc_onehot),
        .touched(touched), .all_touched(flag_valid)
    );

    // Sample only on a strobe that meets a legal access after all die are recorded.
    assign sample_en = rd_strobe && acc_ok && flag_valid;

    mbe_err_sampler u_smp (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .mbe_n(mbe_n),
        .acc_die(acc_die), .err_valid(err_valid), .err_flag(err_flag),
        .err_die(err_die), .err_hit(err_hit)
    );

    mbe_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(err_hit), .clr(err_clr),
        .count(err_count)
    );

    // Register the illegal-pattern indication.
    always_ff @(posedge clk) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= acc_bad;
    end
endmodule

// File: rtl/mbe_qualifier_chk.sv
// Assertion checker for mbe_qualifier, bound to every instance.
module mbe_qualifier_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sleep,
    input logic             err_clr,
    input logic             acc_ok,
    input logic [3:0]       acc_onehot,
    input logic [3:0]       touched,
    input logic             flag_valid,
    input logic             err_valid,
    input logic             proto_err,
    input logic [CNT_W-1:0] err_count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (err_count == '0 && !flag_valid && !err_valid && !proto_err));

    // R3
    one_die_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_onehot));

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_valid) |-> $past(acc_ok));

    // R5
    early_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(flag_valid));

    // R7
    proto_nomark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> (touched == $past(touched)));

    // R8
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !flag_valid);

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count == CNT_MAX && !err_clr) |=> err_count == CNT_MAX);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> err_count == '0);
endmodule

bind mbe_qualifier mbe_qualifier_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .err_clr(err_clr),
    .acc_ok(acc_ok), .acc_onehot(acc_onehot), .touched(touched),
    .flag_valid(flag_valid), .err_valid(err_valid), .proto_err(proto_err),
    .err_count(err_count)
);

// File: tb/mbe_qualifier_test.sv
`timescale 1ns/1ps
module mbe_qualifier_test;
    localparam int CW = 3;
    localparam logic [CW-1:0] CMAX = '1;

    logic clk = 1'b0;
    logic rst_n, sleep, all_en_n, rd_strobe, mbe_n, err_clr;
    logic [3:0] die_en_n;
    logic [1:0] addr_hi;
    logic flag_valid, err_valid, err_flag, proto_err;
    logic [1:0] err_die;
    logic [CW-1:0] err_count;

    int tests = 0;
    int fails = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    mbe_qualifier #(.CNT_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .all_en_n(all_en_n),
        .die_en_n(die_en_n), .addr_hi(addr_hi), .rd_strobe(rd_strobe),
        .mbe_n(mbe_n), .err_clr(err_clr), .flag_valid(flag_valid),
        .err_valid(err_valid), .err_flag(err_flag), .err_die(err_die),
        .proto_err(proto_err), .err_count(err_count)
    );

    // Vector: all_en_n, die_en_n[4], addr_hi[2], strobe, mbe_n |
    //         exp err_valid, exp err_flag, exp err_die[2], exp proto_err
    localparam int NV = 12;
    localparam logic [13:0] TBL [0:NV-1] = '{
        14'b0_1111_00_1_0__1_1_00_0,  // R2 addr 00 -> die 0
        14'b0_1111_01_1_1__1_0_01_0,  // R2 addr 01 -> die 1
        14'b0_1111_10_1_0__1_1_11_0,  // R2 addr 10 -> die 3
        14'b0_1111_11_1_0__1_1_10_0,  // R2 addr 11 -> die 2
        14'b1_1110_11_1_1__1_0_00_0,  // R3 die 0, addr ignored
        14'b1_1101_00_1_0__1_1_01_0,  // R3 die 1
        14'b1_1011_01_1_0__1_1_10_0,  // R3 die 2
        14'b1_0111_10_1_1__1_0_11_0,  // R3 die 3
        14'b0_1111_00_0_0__0_0_11_0,  // R6 no strobe: mbe_n ignored, hold
        14'b0_1110_00_1_0__0_0_11_1,  // R7 combined plus single enable
        14'b1_1100_00_1_0__0_0_11_1,  // R7 two enables
        14'b1_1111_00_1_0__0_0_11_0   // R3 idle: no sample
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic a, input logic [3:0] d, input logic [1:0] ad,
                         input logic s, input logic m, input logic sl, input logic c);
        @(negedge clk);
        all_en_n = a; die_en_n = d; addr_hi = ad; rd_strobe = s;
        mbe_n = m; sleep = sl; err_clr = c;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        drive(1'b1, 4'b1111, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sleep = 1'b0; all_en_n = 1'b1; die_en_n = 4'hF;
        addr_hi = 2'b00; rd_strobe = 1'b0; mbe_n = 1'b1; err_clr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 flag_valid", flag_valid, 0);
        check("R1 err_valid", err_valid, 0);
        check("R1 proto_err", proto_err, 0);
        check("R1 err_count", err_count, 0);
        check("R1 err_flag/die", {err_flag, err_die}, 0);
        @(negedge clk); rst_n = 1'b1;

        // R5 strobes before all die recorded
        drive(1'b1, 4'b1110, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 no sample die0", err_valid, 0);
        drive(1'b1, 4'b1101, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 no sample die1", err_valid, 0);
        drive(1'b1, 4'b1011, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R5 no sample die2", err_valid, 0);
        check("R4 not yet valid", flag_valid, 0);
        check("R5 count unchanged", err_count, 0);
        // R4 / R2: combined mode addr 10 reaches die 3 and completes the set
        drive(1'b0, 4'b1111, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 valid after last die", flag_valid, 1);

        // Table of vectors
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][13], TBL[i][12:9], TBL[i][8:7], TBL[i][6], TBL[i][5], 1'b0, 1'b0);
            if (TBL[i][4] && TBL[i][3] && exp_cnt < int'(CMAX)) exp_cnt++;
            check($sformatf("R6 err_valid vec%0d", i), err_valid, TBL[i][4]);
            check($sformatf("R6 err_flag vec%0d", i), err_flag, TBL[i][3]);
            check($sformatf("R2/R3 err_die vec%0d", i), err_die, TBL[i][2:1]);
            check($sformatf("R7 proto_err vec%0d", i), proto_err, TBL[i][0]);
            check($sformatf("R9 err_count vec%0d", i), err_count, exp_cnt);
        end
        check("R4 valid held", flag_valid, 1);

        // R9 saturation
        for (int i = 0; i < 3; i++)
            drive(1'b0, 4'b1111, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 saturated", err_count, CMAX);
        drive(1'b0, 4'b1111, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 stays at max", err_count, CMAX);

        // R10 clear wins over same-cycle error
        drive(1'b0, 4'b1111, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1);
        check("R10 cleared", err_count, 0);
        drive(1'b0, 4'b1111, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R9 counts after clear", err_count, 1);

        // R8 sleep clears the record and ignores inputs
        drive(1'b0, 4'b1111, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R8 valid cleared", flag_valid, 0);
        check("R8 no sample in sleep", err_valid, 0);
        drive(1'b1, 4'b1101, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
        drive(1'b1, 4'b1011, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
        drive(1'b1, 4'b0111, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0);
        drive(1'b1, 4'b1100, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0);
        check("R8 illegal ignored in sleep", proto_err, 0);
        drive(1'b1, 4'b1110, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 sleep accesses not recorded", flag_valid, 0);
        check("R8 count kept", err_count, 1);

        // R7 illegal pattern does not record a die
        drive(1'b1, 4'b1101, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 4'b1011, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b0, 4'b0111, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 proto raised", proto_err, 1);
        check("R7 die not recorded", flag_valid, 0);
        drive(1'b1, 4'b0111, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R7 proto cleared", proto_err, 0);
        check("R4 valid after real die 3", flag_valid, 1);
        idle();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule